// File: doc/BRIEF.md
# MSI Snooping Cache Controller

This block is the coherence controller that sits beside one processor's small write-back, direct-mapped cache on a shared snooping bus. Each line holds a one-word data value, a tag, and one of three coherence states: Invalid, Shared or Modified. The processor issues loads and stores through a valid/ready request channel. The controller completes hits locally. On a miss or a write to a non-owned line, it requests the bus, waits for a grant and issues a bus transaction. Main memory, or the memory side of the bus, answers reads with a fill.

The controller also watches every transaction that other caches place on the bus. Remote reads demote a Modified line to Shared. Remote writes and invalidations remove the local copy. Whenever a snooped transaction hits a dirty line, the controller drives that line's data on a flush channel, which is used in place of memory. A snoop has priority over the processor in the same cycle: it blocks request acceptance and defers use of a bus grant. The command to issue is chosen in the grant cycle, so a copy that was lost while waiting turns a pending upgrade into a full read-for-ownership.

Back-pressure rules:
- A request transfers on a clock edge where both `cpu_req_valid` and `cpu_req_ready` are high.
- The processor must then hold off until `cpu_rsp_valid` pulses for one cycle. The response has no ready and cannot be stalled.
- `bus_req` stays high until a transaction issues. A transaction issues in a cycle where `bus_out_valid` is high.
- The bus commands are WB=0, RD=1, RDX=2, INV=3. Both the issued commands and the snooped commands use these codes.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is high, and `bus_req`, `cpu_rsp_valid` and `snp_flush_valid` are low.
- R2: A load whose line is absent issues exactly one RD (code 1) for the request address. `cpu_rsp_valid` pulses the cycle after the fill, carrying the fill word, and the line is left Shared.
- R3: A store to a Shared line issues exactly one INV (code 3) and no fill. The line becomes Modified with the store word, and the response returns the store word.
- R4: A store whose line is absent issues exactly one RDX (code 2). After the fill the line is Modified, holding the store word rather than the fill word, and the response returns the store word.
- R5: A load to a Shared or Modified line, or a store to a Modified line, completes with no bus transaction. `cpu_rsp_valid` pulses the cycle after acceptance, carrying the stored word for a load or the store word for a store.
- R6: A snooped RD (code 1) that matches a Modified line pulses `snp_flush_valid` the cycle after the snoop, carrying the line word. The line becomes Shared, so a later local store issues INV.
- R7: A snooped RDX (code 2) or INV (code 3) that matches a line makes it Invalid. A Modified line also flushes its word the cycle after the snoop; a Shared line does not flush.
- R8: A snooped WB (code 0), a snoop that matches no valid line, and a snooped RD on a Shared line produce no flush and leave the line unchanged.
- R9: A miss whose line slot holds a Modified line with a different tag first issues WB (code 0), carrying the victim address and word. It then issues the RD or RDX for the new address.
- R10: While `snp_valid` is high, `cpu_req_ready` is low and no bus transaction issues, even with `bus_gnt` high. The transaction issues in the first granted cycle without a snoop.
- R11: `cpu_req_ready` is high only when no request is outstanding. `bus_req` stays high until a transaction issues, and `bus_out_valid` is only ever high together with `bus_gnt`.
- R12: If a pending store's Shared copy is invalidated by a snoop before the grant, the store issues RDX (code 2) instead of INV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_write | input | 1 | 1 for a store, 0 for a load |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Store word |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Load word, or store word for stores |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Bus granted to this controller |
| bus_out_valid | output | 1 | A transaction is issued this cycle |
| bus_out_cmd | output | 2 | WB=0, RD=1, RDX=2, INV=3 |
| bus_out_addr | output | ADDR_W | Address of the issued transaction |
| bus_out_data | output | DATA_W | Victim word for WB |
| bus_fill_valid | input | 1 | Fill word for the pending RD/RDX |
| bus_fill_data | input | DATA_W | Fill word |
| snp_valid | input | 1 | A remote transaction is on the bus |
| snp_cmd | input | 2 | Remote command, same codes as bus_out_cmd |
| snp_addr | input | ADDR_W | Remote transaction address |
| snp_flush_valid | output | 1 | This cache supplies dirty data |
| snp_flush_data | output | DATA_W | Flushed line word |

## Verification
The assertions check the handshake and ordering rules on every cycle:
- a snoop blocks acceptance and issue;
- an issue needs a grant;
- the bus request is held until it is used;
- a write-back is followed by a further request;
- a flush only follows a snooped non-WB command;
- a fill-type command leaves the bus request dropped.

The state transitions cannot be seen from the ports in any single cycle. These are which transaction a miss or upgrade needs, Modified versus Shared after snoops, victim eviction, and the invalidation race before a grant. The bench's scenarios show them by sweeping load, store and snoop sequences over all lines and two tags per line, comparing each response word, transaction count and command against a model.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_I = 2'd0,
    LN_S = 2'd1,
    LN_M = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_WB  = 2'd0,
    BC_RD  = 2'd1,
    BC_RDX = 2'd2,
    BC_INV = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_GNT  = 2'd1,
    F_FILL = 2'd2
  } fsm_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup port for the processor side
  input  logic [IDX_W-1:0]  a_idx,
  output logic [TAG_W-1:0]  a_tag,
  output line_st_e          a_st,
  output logic [DATA_W-1:0] a_dat,
  // lookup port for the snoop side
  input  logic [IDX_W-1:0]  b_idx,
  output logic [TAG_W-1:0]  b_tag,
  output line_st_e          b_st,
  output logic [DATA_W-1:0] b_dat,
  // full-line write from the processor side
  input  logic              cw_en,
  input  logic [IDX_W-1:0]  cw_idx,
  input  logic [TAG_W-1:0]  cw_tag,
  input  line_st_e          cw_st,
  input  logic [DATA_W-1:0] cw_dat,
  // state-only write from the snoop side
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  line_st_e          sw_st
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_q [LINES];
  line_st_e          st_q  [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  assign a_tag = tag_q[a_idx];
  assign a_st  = st_q[a_idx];
  assign a_dat = dat_q[a_idx];
  assign b_tag = tag_q[b_idx];
  assign b_st  = st_q[b_idx];
  assign b_dat = dat_q[b_idx];

  // The processor-side write is placed last so it wins on a shared index:
  // it installs new contents, while the snoop concerned the old ones.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= LN_I;
        dat_q[i] <= '0;
      end
    end else begin
      if (sw_en) st_q[sw_idx] <= sw_st;
      if (cw_en) begin
        tag_q[cw_idx] <= cw_tag;
        st_q[cw_idx]  <= cw_st;
        dat_q[cw_idx] <= cw_dat;
      end
    end
  end
endmodule

// File: rtl/msi_snoop.sv
module msi_snoop
  import msi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             snp_valid,
  input  logic [1:0]       snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  line_st_e         line_st,
  output logic             upd,
  output line_st_e         nst,
  output logic             flush
);
  logic     hit;
  bus_cmd_e cmd;

  assign cmd = bus_cmd_e'(snp_cmd);
  assign hit = snp_valid && (line_st != LN_I) && (line_tag == snp_tag);

  always_comb begin
    upd   = 1'b0;
    nst   = line_st;
    flush = 1'b0;
    if (hit) begin
      unique case (cmd)
        BC_RD: begin
          if (line_st == LN_M) begin
            upd   = 1'b1;
            nst   = LN_S;
            flush = 1'b1;
          end
        end
        BC_RDX, BC_INV: begin
          upd   = 1'b1;
          nst   = LN_I;
          flush = (line_st == LN_M);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msi_snoop_cache.sv
module msi_snoop_cache
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_out_valid,
  output logic [1:0]        bus_out_cmd,
  output logic [ADDR_W-1:0] bus_out_addr,
  output logic [DATA_W-1:0] bus_out_data,
  input  logic              bus_fill_valid,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_flush_valid,
  output logic [DATA_W-1:0] snp_flush_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  fsm_e              fsm_q, fsm_d;
  logic              rq_wr_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic [DATA_W-1:0] rq_wd_q;

  logic              cur_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wd;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;

  logic [TAG_W-1:0]  l_tag, s_tag;
  line_st_e          l_st, s_st;
  logic [DATA_W-1:0] l_dat, s_dat;

  logic              cw_en;
  logic [TAG_W-1:0]  cw_tag;
  line_st_e          cw_st;
  logic [DATA_W-1:0] cw_dat;

  logic              s_upd, s_flush;
  line_st_e          s_nst;

  logic              accept, tag_hit, victim_dirty, grant_ok;
  logic              rsp_set;
  logic [DATA_W-1:0] rsp_dat_d;
  bus_cmd_e          out_cmd;

  // While idle the lookup follows the incoming request; afterwards the latched one.
  assign cur_wr   = (fsm_q == F_IDLE) ? cpu_req_write : rq_wr_q;
  assign cur_addr = (fsm_q == F_IDLE) ? cpu_req_addr  : rq_addr_q;
  assign cur_wd   = (fsm_q == F_IDLE) ? cpu_req_wdata : rq_wd_q;
  assign cur_idx  = cur_addr[IDX_W-1:0];
  assign cur_tag  = cur_addr[ADDR_W-1:IDX_W];

  msi_line_store #(.TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_idx  (cur_idx),
    .a_tag  (l_tag),
    .a_st   (l_st),
    .a_dat  (l_dat),
    .b_idx  (snp_addr[IDX_W-1:0]),
    .b_tag  (s_tag),
    .b_st   (s_st),
    .b_dat  (s_dat),
    .cw_en  (cw_en),
    .cw_idx (cur_idx),
    .cw_tag (cw_tag),
    .cw_st  (cw_st),
    .cw_dat (cw_dat),
    .sw_en  (s_upd),
    .sw_idx (snp_addr[IDX_W-1:0]),
    .sw_st  (s_nst)
  );

  msi_snoop #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_tag   (snp_addr[ADDR_W-1:IDX_W]),
    .line_tag  (s_tag),
    .line_st   (s_st),
    .upd       (s_upd),
    .nst       (s_nst),
    .flush     (s_flush)
  );

  // Snoops win: they block acceptance and defer use of a grant.
  assign cpu_req_ready = (fsm_q == F_IDLE) && !snp_valid;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign bus_req       = (fsm_q == F_GNT);
  assign grant_ok      = (fsm_q == F_GNT) && bus_gnt && !snp_valid;
  assign tag_hit       = (l_st != LN_I) && (l_tag == cur_tag);
  assign victim_dirty  = (l_st == LN_M) && (l_tag != cur_tag);
  assign bus_out_cmd   = out_cmd;

  always_comb begin
    fsm_d         = fsm_q;
    bus_out_valid = 1'b0;
    out_cmd       = BC_RD;
    bus_out_addr  = cur_addr;
    bus_out_data  = l_dat;
    cw_en         = 1'b0;
    cw_tag        = cur_tag;
    cw_st         = l_st;
    cw_dat        = l_dat;
    rsp_set       = 1'b0;
    rsp_dat_d     = l_dat;
    unique case (fsm_q)
      F_IDLE: begin
        if (accept) begin
          if (tag_hit && !cur_wr) begin
            rsp_set = 1'b1;
          end else if (tag_hit && cur_wr && (l_st == LN_M)) begin
            cw_en     = 1'b1;
            cw_st     = LN_M;
            cw_dat    = cur_wd;
            rsp_set   = 1'b1;
            rsp_dat_d = cur_wd;
          end else begin
            fsm_d = F_GNT;
          end
        end
      end
      F_GNT: begin
        if (grant_ok) begin
          bus_out_valid = 1'b1;
          // The command is chosen from the line state seen in the grant cycle.
          if (victim_dirty) begin
            out_cmd      = BC_WB;
            bus_out_addr = {l_tag, cur_idx};
            cw_en        = 1'b1;
            cw_tag       = l_tag;
            cw_st        = LN_I;
          end else if (cur_wr && tag_hit) begin
            out_cmd   = BC_INV;
            cw_en     = 1'b1;
            cw_st     = LN_M;
            cw_dat    = cur_wd;
            rsp_set   = 1'b1;
            rsp_dat_d = cur_wd;
            fsm_d     = F_IDLE;
          end else begin
            out_cmd = cur_wr ? BC_RDX : BC_RD;
            fsm_d   = F_FILL;
          end
        end
      end
      F_FILL: begin
        if (bus_fill_valid) begin
          cw_en     = 1'b1;
          cw_st     = cur_wr ? LN_M : LN_S;
          cw_dat    = cur_wr ? cur_wd : bus_fill_data;
          rsp_set   = 1'b1;
          rsp_dat_d = cw_dat;
          fsm_d     = F_IDLE;
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q           <= F_IDLE;
      rq_wr_q         <= 1'b0;
      rq_addr_q       <= '0;
      rq_wd_q         <= '0;
      cpu_rsp_valid   <= 1'b0;
      cpu_rsp_rdata   <= '0;
      snp_flush_valid <= 1'b0;
      snp_flush_data  <= '0;
    end else begin
      fsm_q <= fsm_d;
      if (accept) begin
        rq_wr_q   <= cpu_req_write;
        rq_addr_q <= cpu_req_addr;
        rq_wd_q   <= cpu_req_wdata;
      end
      cpu_rsp_valid   <= rsp_set;
      if (rsp_set) cpu_rsp_rdata <= rsp_dat_d;
      snp_flush_valid <= s_flush;
      if (s_flush) snp_flush_data <= s_dat;
    end
  end
endmodule

// File: rtl/msi_snoop_cache_chk.sv
module msi_snoop_cache_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req_ready,
  input logic       cpu_rsp_valid,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       bus_out_valid,
  input logic [1:0] bus_out_cmd,
  input logic       snp_valid,
  input logic [1:0] snp_cmd,
  input logic       snp_flush_valid
);
  // R10: a snoop keeps the processor channel closed
  a_r10_snoop_blocks_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_req_ready);

  // R10: no transaction issues while a snoop is present
  a_r10_no_issue_on_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid |-> !snp_valid);

  // R11: an issue needs the grant
  a_r11_issue_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid |-> (bus_gnt && bus_req));

  // R11: request held until used
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_out_valid) |=> bus_req);

  // R11: processor stalled while the bus is wanted
  a_r11_stall_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_req_ready);

  // R11: completion only when nothing is outstanding on the bus
  a_r11_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> !bus_req);

  // R9: a write-back is always followed by the real request
  a_r9_wb_then_request: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_out_valid && bus_out_cmd == 2'd0) |=> bus_req);

  // R2: a fill-type command leaves the bus request dropped while waiting
  a_r2_fill_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_out_valid && (bus_out_cmd == 2'd1 || bus_out_cmd == 2'd2)) |=> !bus_req);

  // R6: a flush only follows a snooped non-WB command
  a_r6_flush_after_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush_valid |-> ($past(snp_valid) && $past(snp_cmd) != 2'd0));
endmodule

bind msi_snoop_cache msi_snoop_cache_chk u_chk (.*);

// File: tb/tb_msi_snoop_cache.sv
`timescale 1ns/1ps
module tb_msi_snoop_cache;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam int LN = 1 << IW;

  logic          clk, rst_n;
  logic          cpu_req_valid, cpu_req_ready, cpu_req_write;
  logic [AW-1:0] cpu_req_addr;
  logic [DW-1:0] cpu_req_wdata;
  logic          cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          bus_req, bus_gnt, bus_out_valid;
  logic [1:0]    bus_out_cmd;
  logic [AW-1:0] bus_out_addr;
  logic [DW-1:0] bus_out_data;
  logic          bus_fill_valid;
  logic [DW-1:0] bus_fill_data;
  logic          snp_valid;
  logic [1:0]    snp_cmd;
  logic [AW-1:0] snp_addr;
  logic          snp_flush_valid;
  logic [DW-1:0] snp_flush_data;

  msi_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // bench memory and bus agent
  logic [DW-1:0] mem [256];
  logic [1:0]    lg_cmd  [64];
  logic [AW-1:0] lg_addr [64];
  logic [DW-1:0] lg_dat  [64];
  int            n_tx = 0;
  logic          gnt_en = 1'b1;
  logic          fill_pend = 1'b0;
  logic [AW-1:0] fill_addr = '0;

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = DW'(a * 3 + 7);
    bus_gnt = 1'b0;
    bus_fill_valid = 1'b0;
    bus_fill_data = '0;
    forever begin
      @(negedge clk);
      if (fill_pend) begin
        bus_fill_valid = 1'b1;
        bus_fill_data  = mem[fill_addr];
        fill_pend      = 1'b0;
      end else begin
        bus_fill_valid = 1'b0;
      end
      bus_gnt = bus_req && gnt_en;
      #1;
      if (bus_out_valid) begin
        lg_cmd[n_tx % 64]  = bus_out_cmd;
        lg_addr[n_tx % 64] = bus_out_addr;
        lg_dat[n_tx % 64]  = bus_out_data;
        n_tx++;
        if (bus_out_cmd == 2'd0) mem[bus_out_addr] = bus_out_data;
        if (bus_out_cmd == 2'd1 || bus_out_cmd == 2'd2) begin
          fill_pend = 1'b1;
          fill_addr = bus_out_addr;
        end
      end
    end
  end

  // line model: 0 Invalid, 1 Shared, 2 Modified
  int            m_st  [LN];
  int            m_tag [LN];
  logic [DW-1:0] m_dat [LN];

  task automatic issue_only(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_write = w;
    cpu_req_addr  = a;
    cpu_req_wdata = wd;
    while (!cpu_req_ready) @(negedge clk);
    @(posedge clk);
    #1 cpu_req_valid = 1'b0;
  endtask

  task automatic wait_rsp(output logic seen, output logic [DW-1:0] d);
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!cpu_rsp_valid && t < 60);
    seen = cpu_rsp_valid;
    d    = cpu_rsp_rdata;
  endtask

  task automatic cpu_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    int idx, tg, en, tx0;
    string rq, rq2;
    logic hit, seen;
    logic [1:0] ec1;
    logic [AW-1:0] ea0;
    logic [DW-1:0] ewb, ed, got;
    idx = int'(a) % LN;
    tg  = int'(a) / LN;
    hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
    en = 0; ec1 = 2'd0; ea0 = '0; ewb = '0; rq2 = "R5";
    if (!w && hit) begin
      rq = "R5"; ed = m_dat[idx];
    end else if (w && hit && m_st[idx] == 2) begin
      rq = "R5"; ed = wd;
    end else begin
      if (m_st[idx] == 2 && !hit) begin
        ea0 = AW'(m_tag[idx] * LN + idx);
        ewb = m_dat[idx];
        en  = 1;
      end
      if (w && hit) begin ec1 = 2'd3; rq2 = "R3"; ed = wd; end
      else if (w)   begin ec1 = 2'd2; rq2 = "R4"; ed = wd; end
      else          begin ec1 = 2'd1; rq2 = "R2"; ed = mem[a]; end
      en = en + 1;
      rq = rq2;
    end
    if (w) m_st[idx] = 2;
    else if (!hit) m_st[idx] = 1;
    m_tag[idx] = tg;
    m_dat[idx] = ed;
    tx0 = n_tx;
    issue_only(w, a, wd);
    wait_rsp(seen, got);
    chk(seen, rq, 32'(seen), 32'd1);
    chk(got == ed, rq, 32'(got), 32'(ed));
    chk((n_tx - tx0) == en, rq, 32'(n_tx - tx0), 32'(en));
    if (en == 2 && (n_tx - tx0) == 2) begin
      chk(lg_cmd[tx0 % 64] == 2'd0, "R9", 32'(lg_cmd[tx0 % 64]), 32'd0);
      chk(lg_addr[tx0 % 64] == ea0, "R9", 32'(lg_addr[tx0 % 64]), 32'(ea0));
      chk(lg_dat[tx0 % 64] == ewb, "R9", 32'(lg_dat[tx0 % 64]), 32'(ewb));
    end
    if (en >= 1 && (n_tx - tx0) == en) begin
      chk(lg_cmd[(tx0 + en - 1) % 64] == ec1, rq2, 32'(lg_cmd[(tx0 + en - 1) % 64]), 32'(ec1));
      chk(lg_addr[(tx0 + en - 1) % 64] == a, rq2, 32'(lg_addr[(tx0 + en - 1) % 64]), 32'(a));
    end
  endtask

  task automatic snoop_op(input logic [1:0] c, input logic [AW-1:0] a);
    int idx, tg, tx0;
    logic hit, efl;
    logic [DW-1:0] ed;
    string rq;
    idx = int'(a) % LN;
    tg  = int'(a) / LN;
    hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
    efl = hit && (m_st[idx] == 2) && (c != 2'd0);
    ed  = m_dat[idx];
    if (hit && c == 2'd1 && m_st[idx] == 2) rq = "R6";
    else if (hit && c >= 2'd2) rq = "R7";
    else rq = "R8";
    if (hit && c == 2'd1 && m_st[idx] == 2) m_st[idx] = 1;
    if (hit && c >= 2'd2) m_st[idx] = 0;
    tx0 = n_tx;
    @(negedge clk);
    snp_valid = 1'b1;
    snp_cmd   = c;
    snp_addr  = a;
    @(negedge clk);
    snp_valid = 1'b0;
    chk(snp_flush_valid == efl, rq, 32'(snp_flush_valid), 32'(efl));
    if (efl) begin
      chk(snp_flush_data == ed, rq, 32'(snp_flush_data), 32'(ed));
      mem[a] = snp_flush_data;
    end
    chk(n_tx == tx0, rq, 32'(n_tx - tx0), 32'd0);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic seen;
    logic [DW-1:0] got;
    int tx0;
    for (int i = 0; i < LN; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = '0; end
    rst_n = 1'b0;
    cpu_req_valid = 1'b0; cpu_req_write = 1'b0; cpu_req_addr = '0; cpu_req_wdata = '0;
    snp_valid = 1'b0; snp_cmd = 2'd0; snp_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cpu_req_ready == 1'b1, "R1", 32'(cpu_req_ready), 32'd1);
    chk(bus_req == 1'b0, "R1", 32'(bus_req), 32'd0);
    chk(cpu_rsp_valid == 1'b0, "R1", 32'(cpu_rsp_valid), 32'd0);
    chk(snp_flush_valid == 1'b0, "R1", 32'(snp_flush_valid), 32'd0);
    // R1: first load of every line is a miss
    for (int i = 0; i < LN; i++) cpu_op(1'b0, AW'(i), '0);

    // sweep over all lines, two tags each, with interleaved snoops
    for (int i = 0; i < 120; i++) begin
      logic [AW-1:0] a, a2;
      logic w;
      a  = AW'((i * 5 + i / 3) % 8);
      w  = ((i * 3) % 5) < 2;
      cpu_op(w, a, DW'(i * 17 + 1));
      if (i % 3 == 2) begin
        a2 = AW'((i * 7 + 1) % 8);
        snoop_op(2'((i / 3) % 4), a2);
      end
    end

    // R10: a snoop blocks acceptance in the same cycle
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'd0; snp_addr = 8'h00;
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 8'h00;
    #1 chk(cpu_req_ready == 1'b0, "R10", 32'(cpu_req_ready), 32'd0);
    cpu_req_valid = 1'b0;
    @(negedge clk);
    snp_valid = 1'b0;
    #1 chk(cpu_req_ready == 1'b1, "R11", 32'(cpu_req_ready), 32'd1);

    // R10/R11: held request, deferred grant
    snoop_op(2'd2, 8'h05);
    @(posedge clk); #2 gnt_en = 1'b0;
    issue_only(1'b0, 8'h05, '0);
    tx0 = n_tx;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #2;
      chk(bus_req == 1'b1, "R11", 32'(bus_req), 32'd1);
      chk(cpu_req_ready == 1'b0, "R11", 32'(cpu_req_ready), 32'd0);
    end
    @(posedge clk); #2 gnt_en = 1'b1;
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'd0; snp_addr = 8'h02;
    #2;
    chk(bus_gnt == 1'b1, "R10", 32'(bus_gnt), 32'd1);
    chk(bus_out_valid == 1'b0, "R10", 32'(bus_out_valid), 32'd0);
    @(negedge clk);
    snp_valid = 1'b0;
    wait_rsp(seen, got);
    chk(seen && got == mem[8'h05], "R10", 32'(got), 32'(mem[8'h05]));
    chk((n_tx - tx0) == 1 && lg_cmd[tx0 % 64] == 2'd1, "R10", 32'(lg_cmd[tx0 % 64]), 32'd1);
    m_st[1] = 1; m_tag[1] = 1; m_dat[1] = mem[8'h05];

    // R12: upgrade lost to a remote write while waiting for the grant
    snoop_op(2'd2, 8'h06);
    cpu_op(1'b0, 8'h06, '0);
    @(posedge clk); #2 gnt_en = 1'b0;
    issue_only(1'b1, 8'h06, 16'hBEEF);
    snoop_op(2'd2, 8'h06);
    tx0 = n_tx;
    @(posedge clk); #2 gnt_en = 1'b1;
    wait_rsp(seen, got);
    chk(seen && got == 16'hBEEF, "R12", 32'(got), 32'hBEEF);
    chk((n_tx - tx0) == 1, "R12", 32'(n_tx - tx0), 32'd1);
    chk(lg_cmd[tx0 % 64] == 2'd2, "R12", 32'(lg_cmd[tx0 % 64]), 32'd2);
    m_st[2] = 2; m_tag[2] = 1; m_dat[2] = 16'hBEEF;
    cpu_op(1'b0, 8'h06, '0);
    snoop_op(2'd1, 8'h06);
    cpu_op(1'b1, 8'h06, 16'h1234);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule